// File: doc/BRIEF.md
# Scanline-Counted Interrupt Generator

This block raises a processor interrupt after a programmed number of displayed scanlines. Software programs it through four write-only registers. The counter register is loaded directly. The latch register holds the value the counter takes on each expiry. The other two registers disable and enable the interrupt. The video side provides a one-cycle strobe on every scanline, with that line's number and a flag that says whether rendering is on.

On a processed scanline, line 0 first takes one extra decrement if the counter is nonzero. If the counter is then zero, three things happen: a freeze flag is set, the counter is refilled from the latch, and the interrupt is raised. After that step the counter decrements by one on every processed line, wrapping modulo 256.

Once the freeze flag is set, counting stops. It resumes only after software writes any of the four registers. The interrupt output is a level and stays high until software acknowledges it through the disable register.

Top module: `scan_irq_gen`

## Requirements
- R1: After reset, irq_o is low and the counter, latch, enable bit and freeze flag are all zero. Therefore enabling the block and then strobing one eligible line raises irq_o.
- R2: A write is decoded from address bits 15:13 and bit 0, and other address bits are not decoded.
  - 110/0 loads the counter with the data byte.
  - 110/1 loads the latch.
  - 111/0 clears the enable bit and drops irq_o.
  - 111/1 sets the enable bit.
  - Writes to any other page have no effect.
- R3: Any write that R2 decodes clears the freeze flag on the next clock edge.
- R4: A scanline strobe is processed only when all of the following hold; otherwise the strobe changes no state:
  - the line number is 0 to 239;
  - render_en_i is high;
  - the enable bit is set;
  - the freeze flag is clear.
- R5: On a processed strobe for line 0, a nonzero counter first decrements by one.
- R6: If the counter is zero after the R5 step, the freeze flag is set, the counter is reloaded from the latch and irq_o rises. irq_o rises on the clock edge that samples the strobe.
- R7: As the last step of every processed strobe, the counter decrements by one, modulo 256. For example, a latch of 0 leaves the counter at 255.
- R8: irq_o stays high until a 111/0 write or reset. After a 111/0 write it is low from the next clock edge.
- R9: When a decoded write and a scanline strobe occur in the same cycle, the write takes effect and the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_hi_i | input | 3 | Write address bits 15:13 |
| wr_addr_lo_i | input | 1 | Write address bit 0 |
| wr_data_i | input | 8 | Write data |
| line_stb_i | input | 1 | One-cycle pulse at each scanline |
| line_num_i | input | 9 | Number of the current scanline |
| render_en_i | input | 1 | Rendering enabled |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The counter and the freeze flag can only be seen through the time at which irq_o rises. A counter that is off by one moves the next interrupt by one scanline. A freeze flag stuck high suppresses every interrupt after the first, and one stuck low adds interrupts while frozen. Each of these faults therefore appears within one counter period, at most 256 eligible lines. The bench sweeps every pairing of small latch and counter values across full frames, with acknowledges, blanked lines and out-of-range lines mixed in, and compares irq_o on every line against an arithmetic model.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  localparam logic [2:0] PAGE_CNT = 3'b110;
  localparam logic [2:0] PAGE_CTL = 3'b111;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CNT,
    OP_LAT,
    OP_DIS,
    OP_ENA
  } wr_op_e;
endpackage

// File: rtl/scan_irq_dec.sv
module scan_irq_dec
  import scan_irq_pkg::*;
(
  input  logic       wr_en_i,
  input  logic [2:0] addr_hi_i,
  input  logic       addr_lo_i,
  output wr_op_e     op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (wr_en_i) begin
      unique case (addr_hi_i)
        PAGE_CNT: op_o = addr_lo_i ? OP_LAT : OP_CNT;
        PAGE_CTL: op_o = addr_lo_i ? OP_ENA : OP_DIS;
        default:  op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/scan_irq_cnt.sv
module scan_irq_cnt
  import scan_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_op_e            op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

  logic [DATA_W-1:0] cnt_q, lat_q, cnt_pre, cnt_fill, cnt_nxt;
  logic              en_q, frz_q, irq_q, wr_any, in_range, proc, hit;

  assign wr_any   = (op_i != OP_NONE);
  assign in_range = (line_num_i <= LAST);
  assign proc     = line_stb_i && in_range && render_en_i && en_q && !frz_q && !wr_any;

  always_comb begin
    cnt_pre  = ((line_num_i == '0) && (cnt_q != '0)) ? cnt_q - 1'b1 : cnt_q;
    hit      = (cnt_pre == '0);
    cnt_fill = hit ? lat_q : cnt_pre;
    cnt_nxt  = cnt_fill - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
      en_q  <= 1'b0;
      frz_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (wr_any) begin
      frz_q <= 1'b0;
      unique case (op_i)
        OP_CNT: cnt_q <= data_i;
        OP_LAT: lat_q <= data_i;
        OP_DIS: begin en_q <= 1'b0; irq_q <= 1'b0; end
        OP_ENA: en_q <= 1'b1;
        default: ;
      endcase
    end else if (proc) begin
      cnt_q <= cnt_nxt;
      if (hit) begin
        frz_q <= 1'b1;
        irq_q <= 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  p_wr_clr_frz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> !frz_q);
  p_cnt_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CNT |=> cnt_q == $past(data_i));
  p_idle_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && (!line_stb_i || !in_range || !render_en_i)) |=>
      ($stable(cnt_q) && $stable(frz_q) && $stable(irq_q)));
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && frz_q) |=> $stable(cnt_q));
  p_rise_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (frz_q && cnt_q == DATA_W'(lat_q - 1'b1)));
  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DIS |=> !irq_q);
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && op_i != OP_DIS) |=> irq_q);
endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
  import scan_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_hi_i,
  input  logic              wr_addr_lo_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_en_i,
  output logic              irq_o
);
  wr_op_e op;

  scan_irq_dec u_dec (
    .wr_en_i  (wr_en_i),
    .addr_hi_i(wr_addr_hi_i),
    .addr_lo_i(wr_addr_lo_i),
    .op_o     (op)
  );

  scan_irq_cnt #(
    .DATA_W   (DATA_W),
    .LINE_W   (LINE_W),
    .LAST_LINE(LAST_LINE)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .data_i     (wr_data_i),
    .line_stb_i (line_stb_i),
    .line_num_i (line_num_i),
    .render_en_i(render_en_i),
    .irq_o      (irq_o)
  );

  p_irq_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !line_stb_i) |=> !irq_o);
endmodule

// File: tb/sim_scan_irq_gen.sv
module sim_scan_irq_gen;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, addr_lo = 1'b0, stb = 1'b0, ren = 1'b0;
  logic [2:0] addr_hi = '0;
  logic [7:0] data = '0;
  logic [8:0] lnum = '0;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_cnt, m_lat;
  bit         m_en, m_frz, m_irq;

  always #(CLK_P/2) clk = ~clk;

  scan_irq_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_hi_i(addr_hi),
    .wr_addr_lo_i(addr_lo), .wr_data_i(data), .line_stb_i(stb),
    .line_num_i(lnum), .render_en_i(ren), .irq_o(irq)
  );

  task automatic check(string req);
    n_chk++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", req, irq, m_irq);
    end
  endtask

  task automatic m_write(logic [2:0] hi, logic lo, logic [7:0] d);
    if (hi == 3'b110 || hi == 3'b111) begin
      m_frz = 0;
      if (hi == 3'b110 && !lo) m_cnt = d;
      if (hi == 3'b110 && lo)  m_lat = d;
      if (hi == 3'b111 && !lo) begin m_en = 0; m_irq = 0; end
      if (hi == 3'b111 && lo)  m_en = 1;
    end
  endtask

  task automatic m_line(int n, bit r);
    if (n <= 239 && r && m_en && !m_frz) begin
      if (n == 0 && m_cnt != 0) m_cnt = m_cnt - 8'd1;
      if (m_cnt == 0) begin m_frz = 1; m_cnt = m_lat; m_irq = 1; end
      m_cnt = m_cnt - 8'd1;
    end
  endtask

  task automatic do_wr(logic [2:0] hi, logic lo, logic [7:0] d, string req);
    @(negedge clk);
    wr_en = 1; addr_hi = hi; addr_lo = lo; data = d;
    @(negedge clk);
    wr_en = 0;
    m_write(hi, lo, d);
    check(req);
  endtask

  task automatic do_line(int n, bit r, string req);
    @(negedge clk);
    stb = 1; lnum = 9'(n); ren = r;
    @(negedge clk);
    stb = 0;
    m_line(n, r);
    check(req);
  endtask

  task automatic do_both(logic [2:0] hi, logic lo, logic [7:0] d, int n, string req);
    @(negedge clk);
    wr_en = 1; addr_hi = hi; addr_lo = lo; data = d;
    stb = 1; lnum = 9'(n); ren = 1;
    @(negedge clk);
    wr_en = 0; stb = 0;
    m_write(hi, lo, d);
    check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_cnt = 0; m_lat = 0; m_en = 0; m_frz = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");
    // enable bit zero after reset: eligible line must not fire
    do_line(10, 1, "R1 R4 disabled");
    do_wr(3'b111, 1'b1, 8'h00, "R2 enable");
    do_line(11, 1, "R1 zero counter fires");
    do_line(12, 1, "R4 frozen");
    do_line(13, 1, "R8 hold");
    do_wr(3'b111, 1'b0, 8'h00, "R8 ack");
    do_wr(3'b111, 1'b1, 8'h00, "R3 enable clears freeze");
    // undecoded pages must have no effect
    do_wr(3'b110, 1'b1, 8'd3, "R2 latch");
    do_wr(3'b110, 1'b0, 8'd2, "R2 counter");
    do_wr(3'b100, 1'b0, 8'd0, "R2 other page");
    do_wr(3'b101, 1'b1, 8'd0, "R2 other page");
    do_line(240, 1, "R4 out of range");
    do_line(20, 0, "R4 render off");
    do_line(21, 1, "R7 2->1");
    do_line(22, 1, "R7 1->0");
    do_line(23, 1, "R6 fire");
    do_wr(3'b111, 1'b0, 8'h00, "R8 ack");
    do_wr(3'b111, 1'b1, 8'h00, "R3");
    do_both(3'b110, 1'b0, 8'd1, 30, "R9 write wins");
    do_line(31, 1, "R9 then 1->0");
    do_line(32, 1, "R9 fire");
    do_both(3'b111, 1'b0, 8'd0, 40, "R9 ack wins");
    do_wr(3'b111, 1'b1, 8'h00, "R3");
    do_wr(3'b110, 1'b0, 8'd1, "R5 setup");
    do_line(0, 1, "R5 line0 extra decrement fires");

    // sweep latch and counter values over frames
    for (int l = 0; l < 16; l++) begin
      for (int c = 0; c < 16; c++) begin
        do_wr(3'b111, 1'b0, 8'h00, "R8 ack");
        do_wr(3'b110, 1'b1, 8'(l), "R2 latch");
        do_wr(3'b110, 1'b0, 8'(c), "R2 counter");
        do_wr(3'b111, 1'b1, 8'h00, "R2 enable");
        for (int n = 0; n < 244; n++) begin
          do_line(n, ((n + c) % 37) != 5, "R4 R5 R6 R7 frame");
          if (m_irq && ((n + l) % 3 == 0)) begin
            do_wr(3'b111, 1'b0, 8'h00, "R8 ack");
            do_wr(3'b111, 1'b1, 8'h00, "R3 re-enable");
          end
        end
      end
    end
    finish_run();
  end
endmodule